// File: doc/BRIEF.md
# Local Master Address Phase Stage

This block sits between a local-side requester and the bus-facing part of a master engine. It opens a master transaction when the requester pulls the active-low address acknowledge strobe low. On that clock it captures the address, the command and the transfer-width choice. It then drives one address phase towards the bus, or two phases when a dual-address cycle is requested. On the clock after the acknowledge it samples the byte enables, and it keeps them steady until the transaction is closed.

A dual-address cycle is chosen by the requester. It puts the fixed code 4'b1101 on the low command nibble and the real transaction command on the high nibble. The stage then emits the low address half with the fixed code, and on the next cycle the high address half with the real command. Any other low-nibble code is forwarded as it is. An end-of-transaction pulse, or reset, clears everything that is held.

Top module: `apc_master_addr_stage`

## Requirements
- R1: After reset, `aph_valid_o`, `aph_addr_o`, `aph_cmd_o`, `dual_addr_o`, `be_o` and `be_valid_o` are all zero.
- R2: When `adr_ack_n` is low at a rising edge while no transaction is open, the next cycle has `aph_valid_o`=1, `aph_addr_o` equal to bits [31:0] of `loc_ad_i`, and `aph_cmd_o` equal to bits [3:0] of `loc_cbe_i`, all as sampled at that edge.
- R3: For a single-address transaction, where the captured low nibble is not 4'b1101, `aph_valid_o` is high for exactly one cycle, and `dual_addr_o` stays 0.
- R4: When the captured low nibble is 4'b1101, `dual_addr_o` goes to 1. The first phase carries address bits [31:0] with command 4'b1101. The following cycle is a second phase carrying address bits [63:32] with the command from bits [7:4] of the captured `loc_cbe_i`.
- R5: The byte enables are taken from `loc_cbe_i` at the rising edge one clock after the acknowledge edge, not at the acknowledge edge. From the cycle after that edge, `be_valid_o`=1 and `be_o` shows them.
- R6: Once `be_valid_o` is 1, `be_o` does not change until the transaction ends, whatever `loc_cbe_i` does.
- R7: If `wide_i` was 0 at the acknowledge edge, `be_o[7:4]` is held at 4'b1111 (all lanes disabled, active low), and only `be_o[3:0]` carries the sampled enables.
- R8: A high `txn_end_i` at a rising edge while a transaction is open clears all outputs to zero on the next cycle, and a new acknowledge is accepted after that.
- R9: While a transaction is open, a low `adr_ack_n` has no effect: no new address phase appears and the held byte enables stay unchanged.
- R10: Command codes other than 4'b1101 are passed to `aph_cmd_o` unchanged, with no checking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loc_ad_i | input | 64 | Local address/data input |
| loc_cbe_i | input | 8 | Local command / byte-enable input |
| adr_ack_n | input | 1 | Active-low address acknowledge strobe |
| wide_i | input | 1 | 1 = 64-bit data transfer, sampled with the acknowledge |
| txn_end_i | input | 1 | End-of-transaction pulse |
| aph_valid_o | output | 1 | An address phase is being presented |
| aph_addr_o | output | 32 | Address for the current address phase |
| aph_cmd_o | output | 4 | Command for the current address phase |
| dual_addr_o | output | 1 | The open transaction is a dual-address cycle |
| be_o | output | 8 | Held byte enables (active low) |
| be_valid_o | output | 1 | `be_o` holds the sampled enables |

## Verification
The bench aims at the timing of the enable sample. It changes `loc_cbe_i` at the acknowledge, one clock later, and again afterwards, so a stage that takes the enables a cycle too early or keeps following the bus produces a wrong `be_o`. Dual-address cycles are checked with command values different from the fixed code on the high nibble. A stage that swapped the halves or skipped the second phase would show the wrong address or the wrong command. Acknowledge pulses are given in the middle of a transaction, so a stage that reopens the transaction would show a stray phase. Narrow transfers are mixed with wide ones, and end pulses arrive during an address phase, which would expose lane masking and clearing done in the wrong state.

// File: rtl/apc_pkg.sv
package apc_pkg;
    // Fixed low-nibble code that marks a dual-address cycle
    localparam logic [3:0] DUAL_ADDR_CODE = 4'b1101;
    localparam int unsigned CMD_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PH_LO  = 2'd1,
        ST_PH_HI  = 2'd2,
        ST_HOLD   = 2'd3
    } apc_state_e;
endpackage

// File: rtl/apc_cmd_split.sv
module apc_cmd_split
    import apc_pkg::*;
#(
    parameter int unsigned CBE_W = 8
) (
    input  logic [CBE_W-1:0] cbe_i,
    output logic             is_dual_o
);
    // The dual-address marker sits in the low command nibble
    assign is_dual_o = (cbe_i[CMD_W-1:0] == DUAL_ADDR_CODE);
endmodule

// File: rtl/apc_be_mask.sv
module apc_be_mask #(
    parameter int unsigned CBE_W = 8
) (
    input  logic [CBE_W-1:0] be_i,
    input  logic             wide_i,
    output logic [CBE_W-1:0] be_o
);
    localparam int unsigned LANE_HALF = CBE_W / 2;

    // For a narrow transfer the upper lanes are forced to disabled (active low)
    assign be_o = wide_i ? be_i : {{LANE_HALF{1'b1}}, be_i[LANE_HALF-1:0]};
endmodule

// File: rtl/apc_phase_mux.sv
module apc_phase_mux
    import apc_pkg::*;
#(
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned CBE_W  = 8
) (
    input  apc_state_e              st_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [CBE_W-1:0]        cmd_i,
    output logic                    vld_o,
    output logic [ADDR_W/2-1:0]     addr_o,
    output logic [CMD_W-1:0]        cmd_o
);
    localparam int unsigned HALF_W = ADDR_W / 2;

    always_comb begin
        vld_o  = 1'b0;
        addr_o = '0;
        cmd_o  = '0;
        case (st_i)
            ST_PH_LO: begin
                vld_o  = 1'b1;
                addr_o = addr_i[HALF_W-1:0];
                cmd_o  = cmd_i[CMD_W-1:0];
            end
            ST_PH_HI: begin
                vld_o  = 1'b1;
                addr_o = addr_i[ADDR_W-1:HALF_W];
                cmd_o  = cmd_i[2*CMD_W-1:CMD_W];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/apc_master_addr_stage.sv
module apc_master_addr_stage
    import apc_pkg::*;
#(
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned CBE_W  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    loc_ad_i,
    input  logic [CBE_W-1:0]     loc_cbe_i,
    input  logic                 adr_ack_n,
    input  logic                 wide_i,
    input  logic                 txn_end_i,
    output logic                 aph_valid_o,
    output logic [ADDR_W/2-1:0]  aph_addr_o,
    output logic [CMD_W-1:0]     aph_cmd_o,
    output logic                 dual_addr_o,
    output logic [CBE_W-1:0]     be_o,
    output logic                 be_valid_o
);
    typedef struct packed {
        apc_state_e          st;
        logic [ADDR_W-1:0]   addr;
        logic [CBE_W-1:0]    cmd;
        logic                wide;
        logic                dual;
        logic [CBE_W-1:0]    be;
        logic                be_vld;
    } stage_regs_t;

    stage_regs_t regs_d, regs_q;
    logic               dual_in;
    logic [CBE_W-1:0]   be_masked;

    apc_cmd_split #(.CBE_W(CBE_W)) u_split (
        .cbe_i     (loc_cbe_i),
        .is_dual_o (dual_in)
    );

    apc_be_mask #(.CBE_W(CBE_W)) u_mask (
        .be_i   (loc_cbe_i),
        .wide_i (regs_q.wide),
        .be_o   (be_masked)
    );

    apc_phase_mux #(.ADDR_W(ADDR_W), .CBE_W(CBE_W)) u_mux (
        .st_i   (regs_q.st),
        .addr_i (regs_q.addr),
        .cmd_i  (regs_q.cmd),
        .vld_o  (aph_valid_o),
        .addr_o (aph_addr_o),
        .cmd_o  (aph_cmd_o)
    );

    always_comb begin
        regs_d = regs_q;
        case (regs_q.st)
            ST_IDLE: begin
                if (!adr_ack_n) begin
                    regs_d.st   = ST_PH_LO;
                    regs_d.addr = loc_ad_i;
                    regs_d.cmd  = loc_cbe_i;
                    regs_d.wide = wide_i;
                    regs_d.dual = dual_in;
                end
            end
            ST_PH_LO: begin
                // Clock after the acknowledge: take the byte enables
                regs_d.be     = be_masked;
                regs_d.be_vld = 1'b1;
                regs_d.st     = regs_q.dual ? ST_PH_HI : ST_HOLD;
            end
            ST_PH_HI: regs_d.st = ST_HOLD;
            default:  ;
        endcase
        if (regs_q.st != ST_IDLE && txn_end_i) begin
            regs_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign dual_addr_o = regs_q.dual;
    assign be_o        = regs_q.be;
    assign be_valid_o  = regs_q.be_vld;
endmodule

// File: rtl/apc_master_addr_stage_chk.sv
module apc_master_addr_stage_chk #(
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned CBE_W  = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 txn_end_i,
    input logic                 aph_valid_o,
    input logic [3:0]           aph_cmd_o,
    input logic                 dual_addr_o,
    input logic [CBE_W-1:0]     be_o,
    input logic                 be_valid_o
);
    // R3: a single-address phase lasts one cycle
    a_r3_single_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (aph_valid_o && !dual_addr_o) |=> !aph_valid_o);

    // R4: first phase of a dual-address cycle is followed by a second phase
    a_r4_second_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (aph_valid_o && dual_addr_o && !be_valid_o && !txn_end_i) |=> aph_valid_o);

    // R5: enables become valid only right after the first address phase
    a_r5_be_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(be_valid_o) |-> $past(aph_valid_o));

    // R6: held enables stay put until the end pulse
    a_r6_be_held: assert property (@(posedge clk) disable iff (!rst_n)
        (be_valid_o && !txn_end_i) |=> (be_valid_o && $stable(be_o)));

    // R8: end pulse clears held state
    a_r8_end_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_end_i && (aph_valid_o || be_valid_o || dual_addr_o)) |=>
        (!aph_valid_o && !be_valid_o && !dual_addr_o && be_o == '0 && aph_cmd_o == '0));
endmodule

bind apc_master_addr_stage apc_master_addr_stage_chk #(.ADDR_W(ADDR_W), .CBE_W(CBE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .txn_end_i   (txn_end_i),
    .aph_valid_o (aph_valid_o),
    .aph_cmd_o   (aph_cmd_o),
    .dual_addr_o (dual_addr_o),
    .be_o        (be_o),
    .be_valid_o  (be_valid_o)
);

// File: tb/apc_master_addr_stage_bench.sv
module apc_master_addr_stage_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] loc_ad_i = '0;
    logic [7:0]  loc_cbe_i = '0;
    logic        adr_ack_n = 1'b1;
    logic        wide_i = 1'b0;
    logic        txn_end_i = 1'b0;
    logic        aph_valid_o;
    logic [31:0] aph_addr_o;
    logic [3:0]  aph_cmd_o;
    logic        dual_addr_o;
    logic [7:0]  be_o;
    logic        be_valid_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    apc_master_addr_stage u_apc_master_addr_stage (
        .clk(clk), .rst_n(rst_n), .loc_ad_i(loc_ad_i), .loc_cbe_i(loc_cbe_i),
        .adr_ack_n(adr_ack_n), .wide_i(wide_i), .txn_end_i(txn_end_i),
        .aph_valid_o(aph_valid_o), .aph_addr_o(aph_addr_o), .aph_cmd_o(aph_cmd_o),
        .dual_addr_o(dual_addr_o), .be_o(be_o), .be_valid_o(be_valid_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference: phase counter, pending enable sample, held values
    int          m_phase;   // 0 closed, 1 first phase, 2 second phase, 3 holding
    logic [63:0] m_addr;
    logic [7:0]  m_cmd;
    bit          m_wide, m_dual, m_bev;
    logic [7:0]  m_be;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_addr = 0; m_cmd = 0; m_wide = 0; m_dual = 0; m_bev = 0; m_be = 0;
        end else if (m_phase != 0 && txn_end_i) begin
            m_phase = 0; m_addr = 0; m_cmd = 0; m_wide = 0; m_dual = 0; m_bev = 0; m_be = 0;
        end else if (m_phase == 0) begin
            if (!adr_ack_n) begin
                m_phase = 1; m_addr = loc_ad_i; m_cmd = loc_cbe_i; m_wide = wide_i;
                m_dual = (loc_cbe_i[3:0] == 4'd13);
            end
        end else if (m_phase == 1) begin
            m_be  = m_wide ? loc_cbe_i : {4'hF, loc_cbe_i[3:0]};
            m_bev = 1;
            m_phase = m_dual ? 2 : 3;
        end else if (m_phase == 2) begin
            m_phase = 3;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            logic [31:0] ea;
            logic [3:0]  ec;
            ea = (m_phase == 1) ? m_addr[31:0] : (m_phase == 2) ? m_addr[63:32] : 32'h0;
            ec = (m_phase == 1) ? m_cmd[3:0]   : (m_phase == 2) ? m_cmd[7:4]    : 4'h0;
            chk(aph_valid_o == (m_phase == 1 || m_phase == 2), "R2 model valid", aph_valid_o, (m_phase == 1 || m_phase == 2));
            chk(aph_addr_o == ea, "R2 model addr", aph_addr_o, ea);
            chk(aph_cmd_o == ec, "R10 model cmd", aph_cmd_o, ec);
            chk(dual_addr_o == m_dual, "R4 model dual", dual_addr_o, m_dual);
            chk(be_o == m_be && be_valid_o == m_bev, "R6 model be", {be_valid_o, be_o}, {m_bev, m_be});
        end
    end

    // Opens a transaction; returns at the negedge one cycle after the acknowledge edge
    task automatic open_txn(input logic [63:0] a, input logic [7:0] c, input bit w, input logic [7:0] be);
        @(negedge clk);
        loc_ad_i = a; loc_cbe_i = c; wide_i = w; adr_ack_n = 1'b0;
        @(negedge clk);
        adr_ack_n = 1'b1; loc_ad_i = ~a; wide_i = ~w; loc_cbe_i = be;
    endtask

    task automatic close_txn();
        txn_end_i = 1'b1;
        @(negedge clk);
        txn_end_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!aph_valid_o && aph_addr_o == 0 && aph_cmd_o == 0 && !dual_addr_o && be_o == 0 && !be_valid_o,
            "R1 reset outputs", {aph_valid_o, be_valid_o, dual_addr_o, be_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Single address, wide, memory-read style code
        open_txn(64'hDEAD_BEEF_1234_5678, 8'hA6, 1'b1, 8'h3C);
        chk(aph_valid_o && aph_addr_o == 32'h1234_5678, "R2 first phase addr", aph_addr_o, 32'h1234_5678);
        chk(aph_cmd_o == 4'h6, "R10 command passthrough", aph_cmd_o, 4'h6);
        chk(!be_valid_o, "R5 no enables at ack", be_valid_o, 0);
        @(negedge clk);
        loc_cbe_i = 8'h55;
        chk(!aph_valid_o && !dual_addr_o, "R3 single phase", {aph_valid_o, dual_addr_o}, 0);
        chk(be_valid_o && be_o == 8'h3C, "R5 enables from clock after ack", be_o, 8'h3C);
        @(negedge clk);
        chk(be_o == 8'h3C, "R6 enables held", be_o, 8'h3C);
        // Acknowledge while open must be ignored
        loc_ad_i = 64'h0; loc_cbe_i = 8'h07; adr_ack_n = 1'b0;
        @(negedge clk);
        adr_ack_n = 1'b1; loc_cbe_i = 8'h99;
        @(negedge clk);
        chk(!aph_valid_o && be_o == 8'h3C, "R9 ack ignored when open", {aph_valid_o, be_o}, 8'h3C);
        close_txn();
        chk(!be_valid_o && be_o == 0 && !aph_valid_o, "R8 end clears", {be_valid_o, be_o}, 0);

        // Dual address, narrow transfer
        open_txn(64'h0000_00AB_CDEF_0010, 8'h7D, 1'b0, 8'h52);
        chk(aph_addr_o == 32'hCDEF_0010 && aph_cmd_o == 4'hD && dual_addr_o, "R4 dual first phase", {aph_cmd_o, aph_addr_o}, {4'hD, 32'hCDEF_0010});
        @(negedge clk);
        loc_cbe_i = 8'h00;
        chk(aph_valid_o && aph_addr_o == 32'h0000_00AB && aph_cmd_o == 4'h7, "R4 dual second phase", {aph_cmd_o, aph_addr_o}, {4'h7, 32'h0000_00AB});
        chk(be_o == 8'hF2, "R7 narrow upper lanes disabled", be_o, 8'hF2);
        @(negedge clk);
        chk(!aph_valid_o && dual_addr_o && be_o == 8'hF2, "R6 held after dual", {aph_valid_o, be_o}, 8'hF2);
        close_txn();
        chk(!dual_addr_o, "R8 dual flag cleared", dual_addr_o, 0);

        // End pulse during the first address phase, then a new transaction
        open_txn(64'h1111_2222_3333_4444, 8'h0D, 1'b1, 8'h0F);
        close_txn();
        chk(!aph_valid_o && !be_valid_o && !dual_addr_o, "R8 end during phase", {aph_valid_o, be_valid_o, dual_addr_o}, 0);
        open_txn(64'h0000_0000_CAFE_F00D, 8'h4B, 1'b1, 8'hE1);
        chk(aph_valid_o && aph_cmd_o == 4'hB && aph_addr_o == 32'hCAFE_F00D, "R10 reopen after end", {aph_cmd_o, aph_addr_o}, {4'hB, 32'hCAFE_F00D});
        @(negedge clk);
        chk(be_o == 8'hE1, "R7 wide keeps all lanes", be_o, 8'hE1);
        close_txn();
        repeat (2) @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule